// File: doc/BRIEF.md
# Low-Power Stop Mode Controller

This block chooses the stop level the device drops into when the processor issues a STOP instruction. While the device is stopped, it drives the enables for each power and clock domain: the regulator, the clock generator, flash, the debug clock, the real-time-interrupt clock and the I/O hold. The software-programmed levels are stop1, stop2 and stop3. Two conditions force stop3 whatever the power-down configuration says: debug being enabled, and low-voltage detection being armed for stop. Which of the two caused the override decides the domain states.

The override and configuration inputs are captured only at the STOP strobe and are then held until wake. The device wakes on any of these:
- an interrupt request (reset also returns it to run);
- a real-time-interrupt tick, when that clock was kept on;
- a debug background command, when debug was enabled.

The background command leads into an active background state, which a debug go strobe leaves. Debug memory-access commands are refused with a stop/wait error status while the device is stopped.

Top module: `stop_mode_ctl`

## Requirements
- R1: With no override, a STOP strobe in run selects the level from the configuration: power-down=1 with partial=1 gives stop2 (mode 2), power-down=1 with partial=0 gives stop1 (mode 1), and power-down=0 gives stop3 (mode 3). The mode changes on the clock edge that samples the strobe. Run is mode 0.
- R2: If debug enable is 1 at the strobe, the level is stop3, whatever the two configuration bits are.
- R3: If low-voltage enable and low-voltage stop enable are both 1 at the strobe, the level is stop3. Either bit alone has no override effect.
- R4: In stop3 entered with debug enabled: regulator full=1, clock generator on=1, flash on=0, debug clock=1.
- R5: In stop3 forced only by low-voltage detection: regulator full=1, clock generator=0, flash=0, debug clock=0. In any stop level without override, all four are 0.
- R6: I/O hold is 1 in every stop level and 0 in run and in background.
- R7: A debug memory command is granted (grant=1, error=0) in run and background. In any stop level it is refused (grant=0, error=1).
- R8: A background command in stop enters background (mode 4) on the next edge only if debug was enabled at the strobe. Otherwise it has no effect. In background all domain enables are 1. A go strobe returns the device to run.
- R9: The real-time-interrupt clock output in stop equals the source-enable bit captured at the strobe. A tick wakes the device only when that bit was 1.
- R10: An interrupt request in stop returns the mode to run on the next edge, with all domain enables restored to 1.
- R11: Changes to the override inputs, and further STOP strobes, while stopped have no effect on the mode or the domain outputs.
- R12: After reset the mode is run and the regulator, clock generator, flash, debug clock and real-time-interrupt clock enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | STOP instruction strobe |
| cfg_pdown | input | 1 | Power-down configuration bit |
| cfg_partial | input | 1 | Partial power-down configuration bit |
| dbg_en | input | 1 | Debug enable |
| lvd_en | input | 1 | Low-voltage detect enable |
| lvd_stop_en | input | 1 | Low-voltage detect kept in stop |
| rti_src_en | input | 1 | Keep real-time-interrupt clock in stop |
| irq_wake | input | 1 | Enabled interrupt request |
| rti_tick | input | 1 | Real-time-interrupt tick |
| bkgd_cmd | input | 1 | Debug background command strobe |
| dbg_go | input | 1 | Debug go strobe, leaves background |
| mem_cmd | input | 1 | Debug memory-access-with-status command |
| mode | output | 3 | 0 run, 1 stop1, 2 stop2, 3 stop3, 4 background |
| reg_full | output | 1 | Regulator in full regulation |
| clkgen_on | output | 1 | Clock generator active |
| flash_on | output | 1 | Flash active |
| dbg_clk_en | output | 1 | Debug logic clock enable |
| rti_clk_on | output | 1 | Real-time-interrupt clock running |
| io_hold | output | 1 | I/O pin states held |
| mem_grant | output | 1 | Memory command may access memory |
| mem_err | output | 1 | Stop/wait error status for memory command |

## Verification
The bench walks all 32 combinations of the two configuration bits and the three override bits. For each one it checks the level and the domain states. That would catch a design that lets the partial bit leak into the overridden case, or that treats one low-voltage bit on its own as an override. It also checks that a background command without debug leaves the device stopped, and that a tick with the interrupt clock off does not wake it. A design that wakes on any event would fail those checks. Finally, it toggles the override inputs and pulses STOP while stopped. A controller that decodes live inputs instead of captured ones would show changed outputs.

// File: rtl/stop_mode_ctl.sv
module stop_mode_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic       cfg_pdown,
  input  logic       cfg_partial,
  input  logic       dbg_en,
  input  logic       lvd_en,
  input  logic       lvd_stop_en,
  input  logic       rti_src_en,
  input  logic       irq_wake,
  input  logic       rti_tick,
  input  logic       bkgd_cmd,
  input  logic       dbg_go,
  input  logic       mem_cmd,
  output logic [2:0] mode,
  output logic       reg_full,
  output logic       clkgen_on,
  output logic       flash_on,
  output logic       dbg_clk_en,
  output logic       rti_clk_on,
  output logic       io_hold,
  output logic       mem_grant,
  output logic       mem_err
);
  localparam logic [2:0] M_RUN   = 3'd0;
  localparam logic [2:0] M_STOP1 = 3'd1;
  localparam logic [2:0] M_STOP2 = 3'd2;
  localparam logic [2:0] M_STOP3 = 3'd3;
  localparam logic [2:0] M_BKGD  = 3'd4;

  logic dbg_q, lvd_q, rti_q;
  logic in_stop, lvd_arm, ovr, bkgd_ok, wake;
  logic [2:0] level;

  assign lvd_arm = lvd_en & lvd_stop_en;
  assign ovr     = dbg_en | lvd_arm;
  assign level   = ovr ? M_STOP3 :
                   cfg_pdown ? (cfg_partial ? M_STOP2 : M_STOP1) : M_STOP3;
  assign in_stop = (mode == M_STOP1) | (mode == M_STOP2) | (mode == M_STOP3);
  assign bkgd_ok = bkgd_cmd & dbg_q;
  assign wake    = irq_wake | (rti_tick & rti_q) | bkgd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= M_RUN;
      dbg_q <= 1'b0;
      lvd_q <= 1'b0;
      rti_q <= 1'b1;
    end else begin
      case (mode)
        M_RUN: if (stop_req) begin
          mode  <= level;
          dbg_q <= dbg_en;
          lvd_q <= lvd_arm;
          rti_q <= rti_src_en;
        end
        M_BKGD: if (dbg_go) mode <= M_RUN;
        default: if (wake) mode <= bkgd_ok ? M_BKGD : M_RUN;
      endcase
    end
  end

  assign reg_full   = ~in_stop | dbg_q | lvd_q;
  assign clkgen_on  = ~in_stop | dbg_q;
  assign flash_on   = ~in_stop;
  assign dbg_clk_en = ~in_stop | dbg_q;
  assign rti_clk_on = ~in_stop | rti_q;
  assign io_hold    = in_stop;
  assign mem_grant  = mem_cmd & ~in_stop;
  assign mem_err    = mem_cmd & in_stop;

  a_r2_dbg_forces_stop3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RUN && stop_req && dbg_en) |=> mode == M_STOP3);
  a_r3_lvd_forces_stop3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RUN && stop_req && lvd_en && lvd_stop_en) |=> mode == M_STOP3);
  a_r5_flash_standby: assert property (@(posedge clk) disable iff (!rst_n)
    in_stop |-> (!flash_on && io_hold));
  a_r7_no_mem_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
    in_stop |-> !mem_grant);
  a_r8_bkgd_needs_dbg: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && !dbg_clk_en) |=> mode != M_BKGD);
  a_r10_irq_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && irq_wake && !bkgd_cmd) |=> mode == M_RUN);
  a_r11_stop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && !wake) |=> $stable(mode));
endmodule

// File: tb/stop_mode_ctl_tb_top.sv
module stop_mode_ctl_tb_top;
  logic clk = 0, rst_n = 0;
  logic stop_req = 0, cfg_pdown = 0, cfg_partial = 0, dbg_en = 0, lvd_en = 0;
  logic lvd_stop_en = 0, rti_src_en = 0, irq_wake = 0, rti_tick = 0;
  logic bkgd_cmd = 0, dbg_go = 0, mem_cmd = 0;
  logic [2:0] mode;
  logic reg_full, clkgen_on, flash_on, dbg_clk_en, rti_clk_on, io_hold, mem_grant, mem_err;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  stop_mode_ctl dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic enter_stop(input bit pd, input bit pp, input bit dbg, input bit le,
                            input bit ls, input bit rti);
    @(negedge clk);
    cfg_pdown = pd; cfg_partial = pp; dbg_en = dbg; lvd_en = le; lvd_stop_en = ls;
    rti_src_en = rti; stop_req = 1;
    @(negedge clk);
    stop_req = 0;
  endtask

  task automatic wake_irq();
    irq_wake = 1;
    @(negedge clk);
    irq_wake = 0;
  endtask

  task automatic t_reset();
    chk("R12 mode", mode, 0);
    chk("R12 domains", {reg_full, clkgen_on, flash_on, dbg_clk_en, rti_clk_on}, 5'b11111);
    chk("R6 run io_hold", io_hold, 0);
  endtask

  task automatic t_all_combos();
    for (int i = 0; i < 32; i++) begin
      bit pd, pp, dbg, le, ls, ovr;
      int lvl;
      {pd, pp, dbg, le, ls} = i[4:0];
      ovr = dbg | (le & ls);
      lvl = ovr ? 3 : (pd ? (pp ? 2 : 1) : 3);
      enter_stop(pd, pp, dbg, le, ls, 0);
      chk(ovr ? (dbg ? "R2 level" : "R3 level") : "R1 level", mode, lvl);
      chk(dbg ? "R4 domains" : "R5 domains", {reg_full, clkgen_on, flash_on, dbg_clk_en},
          {ovr, dbg, 1'b0, dbg});
      chk("R6 stop io_hold", io_hold, 1);
      wake_irq();
      chk("R10 wake mode", mode, 0);
      chk("R10 restored", {reg_full, clkgen_on, flash_on, dbg_clk_en, io_hold}, 5'b11110);
    end
  endtask

  task automatic t_mem();
    mem_cmd = 1; #1;
    chk("R7 run grant", {mem_grant, mem_err}, 2'b10);
    mem_cmd = 0;
    enter_stop(1, 0, 0, 0, 0, 0);
    mem_cmd = 1; #1;
    chk("R7 stop refuse", {mem_grant, mem_err}, 2'b01);
    mem_cmd = 0;
    wake_irq();
  endtask

  task automatic t_bkgd();
    enter_stop(1, 1, 0, 0, 0, 0);
    bkgd_cmd = 1; @(negedge clk); bkgd_cmd = 0;
    chk("R8 bkgd ignored without debug", mode, 2);
    wake_irq();
    enter_stop(1, 1, 1, 0, 0, 0);
    bkgd_cmd = 1; @(negedge clk); bkgd_cmd = 0;
    chk("R8 bkgd entered", mode, 4);
    chk("R8 bkgd domains", {reg_full, clkgen_on, flash_on, dbg_clk_en, io_hold}, 5'b11110);
    mem_cmd = 1; #1;
    chk("R7 bkgd grant", {mem_grant, mem_err}, 2'b10);
    mem_cmd = 0;
    dbg_go = 1; @(negedge clk); dbg_go = 0;
    chk("R8 go to run", mode, 0);
  endtask

  task automatic t_rti();
    enter_stop(1, 0, 0, 0, 0, 0);
    chk("R9 rti clk off", rti_clk_on, 0);
    rti_tick = 1; @(negedge clk); rti_tick = 0;
    chk("R9 tick ignored", mode, 1);
    wake_irq();
    enter_stop(1, 0, 0, 0, 0, 1);
    chk("R9 rti clk on", rti_clk_on, 1);
    rti_tick = 1; @(negedge clk); rti_tick = 0;
    chk("R9 tick wakes", mode, 0);
  endtask

  task automatic t_hold();
    enter_stop(0, 0, 1, 0, 0, 0);
    dbg_en = 0; lvd_en = 1; lvd_stop_en = 1; cfg_pdown = 1; cfg_partial = 1; stop_req = 1;
    @(negedge clk); stop_req = 0;
    chk("R11 mode held", mode, 3);
    chk("R11 domains held", {reg_full, clkgen_on, flash_on, dbg_clk_en}, 4'b1101);
    bkgd_cmd = 1; @(negedge clk); bkgd_cmd = 0;
    chk("R11 captured debug used", mode, 4);
    dbg_go = 1; @(negedge clk); dbg_go = 0;
    lvd_en = 0; lvd_stop_en = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_all_combos();
    t_mem();
    t_bkgd();
    t_rti();
    t_hold();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule